// File: doc/BRIEF.md
# Pulse-Swallow Divider Back End

This block is the programmable half of an integer-N pulse-swallow frequency divider. A dual-modulus prescaler, outside this block, divides the fast clock by N or N+1. Each time it completes one output cycle it raises a one-clock strobe, and this block counts those strobes. From the count it produces the divider's output pulse once per programmed period. It also drives the modulus-control line back to the prescaler, so that the first S prescaler cycles of each period use N+1 and the rest use N. The total division is N·P+S.

Two counters run in the same clock domain, and both advance only on the prescaler strobe. The program counter wraps after P strobes and emits the output pulse. The swallow counter raises modulus control after S strobes. It then freezes, because its own enable is gated by modulus control, and it stays frozen until the output pulse clears it. Both control words are written as the wanted count minus one, because state zero is one of the counted states. Each control word is copied into a shadow register at reset and at every output pulse. A change to an input in the middle of a period therefore applies only from the next period.

Top module: `pswl_backend`

## Requirements
- R1: When `rst` is high at a clock edge, `div_out` and `mod_ctrl` become 0 and both counters return to zero. The shadow registers then capture `prog_val` and `swal_val`.
- R2: With a program shadow value p, `div_out` goes high for exactly one clock after every (p+1)-th strobe of `pre_tick`. This holds for every p from 0 to 127.
- R3: A clock in which `pre_tick` is low changes neither output, and `div_out` stays low in that clock. Idle clocks between strobes do not change the number of strobes per period.
- R4: `mod_ctrl` is low at the start of each period. With a swallow shadow value s that is lower than p, `mod_ctrl` rises in the clock after the (s+1)-th strobe of the period. It then stays high for the remaining p−s strobes of the period.
- R5: `mod_ctrl` is low in every clock where `div_out` is high. The output pulse clears the swallow counter.
- R6: If s ≥ p, the program terminal count takes priority and `mod_ctrl` stays low for the whole period.
- R7: A change to `prog_val` or `swal_val` during a period does not alter that period. The new value governs from the following period.
- R8: With a prescaler that divides by N when `mod_ctrl` is 1 and by N+1 when it is 0, consecutive output pulses are N·P+S fast clocks apart. Here P = p+1 and S = s+1. With N=32, p=76 and s=5 the spacing is 2470 clocks. With N=47, p=121 and s=37 it is 5772 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the prescaler strobe |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 1 | One-clock strobe per prescaler output cycle |
| prog_val | input | 7 | Program count minus one (P−1) |
| swal_val | input | 6 | Swallow count minus one (S−1) |
| div_out | output | 1 | One-clock divider output pulse |
| mod_ctrl | output | 1 | Modulus control to prescaler: 0 selects N+1, 1 selects N |

## Verification
The assertions check the following on every cycle:
- Reset clears both outputs.
- An output pulse or a rise of modulus control occurs only after a strobe.
- An idle clock leaves modulus control unchanged and keeps the pulse low.
- Modulus control is never high together with the output pulse.

Only the bench scenarios can show the behaviours that depend on counts:
- the number of strobes per period and the number of strobes spent with modulus control high, across several control values and idle gaps;
- shadowing of mid-period changes;
- the full division ratio through a modelled prescaler.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
    localparam int PROG_W_DEF = 7;
    localparam int SWAL_W_DEF = 6;
endpackage

// File: rtl/pswl_prog_ctr.sv
module pswl_prog_ctr #(
    parameter int W = pswl_pkg::PROG_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] limit_in,
    output logic         term_o,
    output logic         pulse_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] shadow;
        logic         pulse;
    } prog_st_t;

    prog_st_t st_d, st_q;
    logic     hit;

    assign hit = tick && (st_q.cnt == st_q.shadow);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (rst) begin
            st_d.cnt    = '0;
            st_d.shadow = limit_in;
        end else if (hit) begin
            st_d.cnt    = '0;
            st_d.pulse  = 1'b1;
            st_d.shadow = limit_in;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign term_o  = hit;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/pswl_swal_ctr.sv
module pswl_swal_ctr #(
    parameter int W = pswl_pkg::SWAL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] limit_in,
    output logic         mod_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] shadow;
        logic         mod;
    } swal_st_t;

    swal_st_t st_d, st_q;
    logic     run;

    // counting stops once modulus control is up
    assign run = tick && !st_q.mod;

    always_comb begin
        st_d = st_q;
        if (rst || clear) begin
            st_d.cnt    = '0;
            st_d.mod    = 1'b0;
            st_d.shadow = limit_in;
        end else if (run) begin
            if (st_q.cnt == st_q.shadow) begin
                st_d.mod = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mod_o = st_q.mod;
endmodule

// File: rtl/pswl_backend.sv
module pswl_backend #(
    parameter int PROG_W = pswl_pkg::PROG_W_DEF,
    parameter int SWAL_W = pswl_pkg::SWAL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_tick,
    input  logic [PROG_W-1:0] prog_val,
    input  logic [SWAL_W-1:0] swal_val,
    output logic              div_out,
    output logic              mod_ctrl
);
    logic period_end;

    pswl_prog_ctr #(.W(PROG_W)) prog_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (pre_tick),
        .limit_in (prog_val),
        .term_o   (period_end),
        .pulse_o  (div_out)
    );

    pswl_swal_ctr #(.W(SWAL_W)) swal_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (pre_tick),
        .clear    (period_end),
        .limit_in (swal_val),
        .mod_o    (mod_ctrl)
    );
endmodule

// File: rtl/pswl_backend_chk.sv
module pswl_backend_chk (
    input logic clk,
    input logic rst,
    input logic pre_tick,
    input logic div_out,
    input logic mod_ctrl
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!div_out && !mod_ctrl));

    // R2
    a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
        div_out |-> $past(pre_tick));

    // R3
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !pre_tick |=> ($stable(mod_ctrl) && !div_out));

    // R4
    a_r4_mod_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_ctrl) |-> ($past(pre_tick) && !div_out));

    // R5
    a_r5_mod_low_at_pulse: assert property (@(posedge clk) disable iff (rst)
        div_out |-> !mod_ctrl);
endmodule

bind pswl_backend pswl_backend_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .pre_tick (pre_tick),
    .div_out  (div_out),
    .mod_ctrl (mod_ctrl)
);

// File: tb/pswl_backend_tb.sv
module pswl_backend_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_man = 1'b0;
    logic       tick_ps = 1'b0;
    logic       ps_on = 1'b0;
    logic [6:0] prog_val = '0;
    logic [5:0] swal_val = '0;
    logic       pre_tick;
    logic       div_out;
    logic       mod_ctrl;
    int         tests = 0;
    int         fails = 0;
    int         nmod = 32;
    int         rem = 0;
    int         cyc = 0;

    assign pre_tick = ps_on ? tick_ps : tick_man;

    always #5 clk = ~clk;

    pswl_backend dut_i (
        .clk      (clk),
        .rst      (rst),
        .pre_tick (pre_tick),
        .prog_val (prog_val),
        .swal_val (swal_val),
        .div_out  (div_out),
        .mod_ctrl (mod_ctrl)
    );

    // dual-modulus prescaler model: N when mod_ctrl=1, N+1 otherwise
    always @(negedge clk) begin
        if (ps_on) begin
            if (rem == 0) rem = mod_ctrl ? nmod : nmod + 1;
            rem = rem - 1;
            tick_ps <= (rem == 0);
        end else begin
            rem = 0;
            tick_ps <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: act %0d cycles exp <= 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int p, input int s);
        tick_man = 1'b0;
        prog_val = 7'(p);
        swal_val = 6'(s);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_man = 1'b1;
            @(negedge clk);
        end
        tick_man = 1'b0;
    endtask

    // drive strobes until div_out appears; count strobes and strobes seen with mod high
    task automatic run_period(input int gap, output int nt, output int nh);
        int idle;
        idle = 0;
        nt = 0;
        nh = 0;
        forever begin
            @(negedge clk);
            if (div_out || nt > 1000) break;
            if (idle > 0) begin
                tick_man = 1'b0;
                idle--;
            end else begin
                tick_man = 1'b1;
                nt++;
                if (mod_ctrl) nh++;
                idle = gap;
            end
        end
        tick_man = 1'b0;
    endtask

    localparam int NV = 7;
    localparam int VP[NV]  = '{3, 0, 5, 5, 10, 127, 6};
    localparam int VS[NV]  = '{1, 0, 5, 9, 0, 63, 5};
    localparam int VG[NV]  = '{0, 0, 2, 1, 0, 0, 3};
    localparam int ET[NV]  = '{4, 1, 6, 6, 11, 128, 7};
    localparam int EH[NV]  = '{2, 0, 0, 0, 10, 64, 1};

    initial begin
        int nt, nh, clocks;

        do_reset(3, 1);
        @(negedge clk);
        chk(!div_out && !mod_ctrl, "R1 reset outputs", {div_out, mod_ctrl}, 0);

        // table: R2 strobes per period, R4/R6 strobes with mod high, R5 mod low at pulse
        for (int v = 0; v < NV; v++) begin
            do_reset(VP[v], VS[v]);
            for (int rep = 0; rep < 2; rep++) begin
                run_period(VG[v], nt, nh);
                chk(nt == ET[v], "R2 strobes per period", nt, ET[v]);
                chk(nh == EH[v], (VS[v] >= VP[v]) ? "R6 mod stays low" : "R4 mod-high strobes", nh, EH[v]);
                chk(!mod_ctrl, "R5 mod low with pulse", mod_ctrl, 0);
                @(negedge clk);
                chk(!div_out, "R2 pulse one clock wide", div_out, 0);
            end
        end

        // R4 rise point and R3 idle hold, then R1 reset from a busy state
        do_reset(10, 0);
        @(negedge clk);
        chk(!mod_ctrl, "R4 mod low before first strobe", mod_ctrl, 0);
        send_ticks(1);
        chk(mod_ctrl, "R4 mod high after s+1 strobes", mod_ctrl, 1);
        repeat (10) @(negedge clk);
        chk(mod_ctrl && !div_out, "R3 idle keeps state", {div_out, mod_ctrl}, 1);
        run_period(0, nt, nh);
        chk(nt == 10, "R3 strobe count unaffected by idle", nt, 10);
        send_ticks(2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!div_out && !mod_ctrl, "R1 reset from mid period", {div_out, mod_ctrl}, 0);

        // R7 mid-period change is shadowed
        do_reset(9, 20);
        send_ticks(3);
        prog_val = 7'd2;
        run_period(0, nt, nh);
        chk(nt == 7, "R7 current period keeps old value", nt, 7);
        @(negedge clk);
        run_period(0, nt, nh);
        chk(nt == 3, "R7 next period uses new value", nt, 3);

        // R8 full ratio through prescaler model
        for (int k = 0; k < 2; k++) begin
            int expv;
            nmod = (k == 0) ? 32 : 47;
            expv = (k == 0) ? 2470 : 5772;
            do_reset((k == 0) ? 76 : 121, (k == 0) ? 5 : 37);
            ps_on = 1'b1;
            while (!div_out) @(negedge clk);
            for (int rep = 0; rep < 2; rep++) begin
                clocks = 0;
                do begin
                    @(negedge clk);
                    clocks++;
                end while (!div_out && clocks < 20000);
                chk(clocks == expv, "R8 clocks between pulses", clocks, expv);
            end
            ps_on = 1'b0;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule